// File: doc/BRIEF.md
# Multilevel Page Table Walker

This block turns a virtual address into a physical address by walking a tree of page tables held in memory. A walk starts from a physical base address supplied on the `ptbr` input. The virtual address is cut into one index field per level, most significant field first, with the page offset below them. At each level the block reads one table entry at address base + index × 4. An entry at an inner level gives the page-aligned base of the table one level down. The entry at the last level gives the frame number, and the frame number is joined with the page offset to form the physical address.

Every entry read is checked. An entry whose present flag is clear ends the walk with a page fault. At the last level, a write access to a page that is not writable ends the walk with a protection fault. A walk that completes sets the referenced flag of the last entry, and on a write access it also sets the modified flag. The changed entry is written back to memory before the result is reported. If neither flag changes, no write is issued. The cache-disable flag of the last entry is passed out with the result.

The block accepts one request at a time. It reports each walk with a one-cycle result pulse. One request/response memory port carries all reads and write-backs.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `mem_req_valid` and `done_valid` are 0.
- R2: The first read of a walk is at address `ptbr` + (top index field × 4). The top index field is `vaddr[VA_W-1 -: IDX_W]`.
- R3: Each later read is at {PPN of the previous entry, OFF_W zero bits} + (that level's index × 4). The PPN is entry bits [PTE_W-1 -: PA_W-OFF_W]. A write-back goes to the address of the last entry read.
- R4: A walk with no fault makes exactly LEVELS reads. It reports `done_paddr` = {last entry PPN, vaddr[OFF_W-1:0]} and `done_fault` = 0.
- R5: An entry at any level with present flag (bit 0) = 0 ends the walk at once. The walk reports `done_fault` = 1, makes no further read and makes no write.
- R6: A write access whose last entry has writable flag (bit 1) = 0 reports `done_fault` = 2 and makes no write-back. A read access to that entry completes normally.
- R7: A completed walk whose last entry has referenced flag (bit 2) = 0 writes the entry back with bit 2 set. All other bits are unchanged.
- R8: A completed write access whose last entry has modified flag (bit 3) = 0 writes the entry back with bits 2 and 3 set.
- R9: When bits 2 and 3 need no change, no memory write is issued. Any write-back is acknowledged before `done_valid` rises.
- R10: `done_nocache` equals the cache-disable flag (bit 4) of the last entry of a completed walk.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address, write flag and data stay unchanged in the next cycle.
- R12: `req_ready` is 0 from acceptance until the result. `done_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptbr | input | PA_W | Byte address of the top-level table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write-back |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_req_wdata | output | PTE_W | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Response for the oldest request |
| mem_rsp_rdata | input | PTE_W | Entry read from memory |
| done_valid | output | 1 | One-cycle result pulse |
| done_paddr | output | PA_W | Physical address, 0 on fault |
| done_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| done_nocache | output | 1 | Cache-disable flag of the final entry |

## Verification
The bench builds the walker with two levels, 3-bit index fields, a 5-bit offset and a 10-bit physical address. A whole table then fits in 32 bytes and a 1 KB memory model holds several tables. Faults at the top and at the last level can be placed side by side in that memory, along with a read-only page, an uncached page and the highest frame number. A base register that is not page-aligned and a memory that stalls on alternate cycles are also reached. Counting reads and writes in the memory model shows the access count per level and the suppressed write-backs.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;

    localparam int FLAG_W       = 5;
    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;
    localparam int BIT_REF      = 2;
    localparam int BIT_MOD      = 3;
    localparam int BIT_NOCACHE  = 4;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WB_REQ,
        ST_WB_WAIT,
        ST_DONE
    } walk_state_e;

    // packed order places present at bit 0
    typedef struct packed {
        logic nocache;
        logic modified;
        logic referenced;
        logic writable;
        logic present;
    } pte_flags_t;

    function automatic pte_flags_t flags_of(input logic [FLAG_W-1:0] raw);
        return pte_flags_t'(raw);
    endfunction

endpackage

// File: rtl/pt_index_sel.sv
`timescale 1ns/1ps
module pt_index_sel #(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 11,
    parameter int OFF_W  = 13,
    parameter int VA_W   = LEVELS*IDX_W + OFF_W,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] field [LEVELS];

    // level 0 takes the most significant index field
    for (genvar l = 0; l < LEVELS; l++) begin : g_field
        assign field[l] = vaddr[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) idx = field[l];
        end
    end
endmodule

// File: rtl/pt_entry_addr.sv
`timescale 1ns/1ps
module pt_entry_addr #(
    parameter int PA_W  = 33,
    parameter int IDX_W = 11
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);
    localparam int SCALED_W = IDX_W + 2;

    logic [SCALED_W-1:0] scaled;

    assign scaled = {idx, 2'b00};
    assign addr   = base + PA_W'(scaled);
endmodule

// File: rtl/pt_entry_check.sv
`timescale 1ns/1ps
module pt_entry_check
    import pt_walker_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PA_W  = 33,
    parameter int OFF_W = 13,
    parameter int PPN_W = PA_W - OFF_W
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_last,
    input  logic             is_write,
    output fault_e           fault,
    output logic             needs_wb,
    output logic [PTE_W-1:0] pte_upd,
    output logic [PA_W-1:0]  next_base,
    output logic             nocache
);
    pte_flags_t       fl;
    logic [PPN_W-1:0] ppn;

    assign fl        = flags_of(pte[FLAG_W-1:0]);
    assign ppn       = pte[PTE_W-1 -: PPN_W];
    assign next_base = {ppn, {OFF_W{1'b0}}};
    assign nocache   = fl.nocache;

    always_comb begin
        if (!fl.present) begin
            fault = FLT_PAGE;
        end else if (is_last && is_write && !fl.writable) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end

    always_comb begin
        pte_upd               = pte;
        pte_upd[BIT_REF]      = 1'b1;
        pte_upd[BIT_MOD]      = pte[BIT_MOD] | is_write;
    end

    assign needs_wb = is_last && (pte_upd != pte);
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 11,
    parameter int OFF_W  = 13,
    parameter int PA_W   = 33,
    parameter int PTE_W  = 32,
    parameter int VA_W   = LEVELS*IDX_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PA_W-1:0]  ptbr,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic [PTE_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_rdata,
    output logic             done_valid,
    output logic [PA_W-1:0]  done_paddr,
    output logic [1:0]       done_fault,
    output logic             done_nocache
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int PPN_W = PA_W - OFF_W;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e      state;
    logic [LVL_W-1:0] level;
    logic [PA_W-1:0]  base_q;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic [PA_W-1:0]  ent_addr_q;
    logic [PTE_W-1:0] pte_q;
    logic [PA_W-1:0]  paddr_q;
    fault_e           fault_q;
    logic             nc_q;

    logic [IDX_W-1:0] cur_idx;
    logic [PA_W-1:0]  rd_addr;
    fault_e           chk_fault;
    logic             chk_wb;
    logic [PTE_W-1:0] chk_upd;
    logic [PA_W-1:0]  chk_base;
    logic             chk_nc;
    logic             is_last;

    assign is_last = (level == LAST_LVL);

    pt_index_sel #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .VA_W(VA_W), .LVL_W(LVL_W)
    ) u_idx (
        .vaddr (va_q),
        .level (level),
        .idx   (cur_idx)
    );

    pt_entry_addr #(
        .PA_W(PA_W), .IDX_W(IDX_W)
    ) u_addr (
        .base (base_q),
        .idx  (cur_idx),
        .addr (rd_addr)
    );

    pt_entry_check #(
        .PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)
    ) u_chk_ent (
        .pte       (mem_rsp_rdata),
        .is_last   (is_last),
        .is_write  (wr_q),
        .fault     (chk_fault),
        .needs_wb  (chk_wb),
        .pte_upd   (chk_upd),
        .next_base (chk_base),
        .nocache   (chk_nc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            level      <= '0;
            base_q     <= '0;
            va_q       <= '0;
            wr_q       <= 1'b0;
            ent_addr_q <= '0;
            pte_q      <= '0;
            paddr_q    <= '0;
            fault_q    <= FLT_NONE;
            nc_q       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        wr_q   <= req_write;
                        base_q <= ptbr;
                        level  <= '0;
                        state  <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (mem_req_ready) begin
                        ent_addr_q <= rd_addr;
                        state      <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (chk_fault != FLT_NONE) begin
                            fault_q <= chk_fault;
                            paddr_q <= '0;
                            nc_q    <= 1'b0;
                            state   <= ST_DONE;
                        end else if (!is_last) begin
                            base_q <= chk_base;
                            level  <= level + LVL_W'(1);
                            state  <= ST_RD_REQ;
                        end else begin
                            fault_q <= FLT_NONE;
                            paddr_q <= {chk_base[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                            nc_q    <= chk_nc;
                            pte_q   <= chk_upd;
                            state   <= chk_wb ? ST_WB_REQ : ST_DONE;
                        end
                    end
                end
                ST_WB_REQ: begin
                    if (mem_req_ready) state <= ST_WB_WAIT;
                end
                ST_WB_WAIT: begin
                    if (mem_rsp_valid) state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WB_REQ);
    assign mem_req_write = (state == ST_WB_REQ);
    assign mem_req_addr  = (state == ST_WB_REQ) ? ent_addr_q : rd_addr;
    assign mem_req_wdata = (state == ST_WB_REQ) ? pte_q : '0;
    assign done_valid    = (state == ST_DONE);
    assign done_paddr    = paddr_q;
    assign done_fault    = fault_q;
    assign done_nocache  = nc_q;
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk
    import pt_walker_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 11,
    parameter int OFF_W  = 13,
    parameter int PA_W   = 33,
    parameter int PTE_W  = 32,
    parameter int VA_W   = LEVELS*IDX_W + OFF_W
) (
    input logic             clk,
    input logic             rst,
    input logic [PA_W-1:0]  ptbr,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_write,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_write,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic [PTE_W-1:0] mem_req_wdata,
    input logic             done_valid,
    input logic [1:0]       done_fault
);
    logic            first_q;
    logic            wrote_q;
    logic            wr_cap;
    logic [PA_W-1:0] ptbr_cap;
    logic [IDX_W-1:0] top_idx_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q     <= 1'b0;
            wrote_q     <= 1'b0;
            wr_cap      <= 1'b0;
            ptbr_cap    <= '0;
            top_idx_cap <= '0;
        end else if (req_valid && req_ready) begin
            first_q     <= 1'b1;
            wrote_q     <= 1'b0;
            wr_cap      <= req_write;
            ptbr_cap    <= ptbr;
            top_idx_cap <= req_vaddr[VA_W-1 -: IDX_W];
        end else if (mem_req_valid && mem_req_ready) begin
            first_q <= 1'b0;
            if (mem_req_write) wrote_q <= 1'b1;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !mem_req_valid && !done_valid));

    p_first_read_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && first_q) |->
            (!mem_req_write && mem_req_addr == ptbr_cap + PA_W'({top_idx_cap, 2'b00})));

    p_fault_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault != FLT_NONE) |-> !wrote_q);

    p_prot_only_write_r6: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault == FLT_PROT) |-> wr_cap);

    p_wb_sets_ref_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[BIT_REF]);

    p_wb_sets_mod_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && wr_cap) |-> mem_req_wdata[BIT_MOD]);

    p_req_held_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || done_valid) |-> !req_ready);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);
endmodule

bind pt_walker pt_walker_chk #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .PA_W(PA_W), .PTE_W(PTE_W), .VA_W(VA_W)
) u_walker_chk (
    .clk           (clk),
    .rst           (rst),
    .ptbr          (ptbr),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .done_valid    (done_valid),
    .done_fault    (done_fault)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    localparam int BL   = 2;
    localparam int BI   = 3;
    localparam int BO   = 5;
    localparam int BPA  = 10;
    localparam int BPTE = 32;
    localparam int BVA  = BL*BI + BO;
    localparam int WORDS = 1 << (BPA - 2);

    localparam logic [4:0] FP = 5'd1, FW = 5'd2, FR = 5'd4, FM = 5'd8, FC = 5'd16;

    typedef struct packed {
        logic [BVA-1:0] va;
        logic           wr;
        logic [1:0]     flt;
        logic [BPA-1:0] pa;
        logic           nc;
        logic [1:0]     nrd;
        logic           nwr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{va: 11'd7,   wr: 1'b0, flt: 2'd0, pa: 10'd327, nc: 1'b0, nrd: 2'd2, nwr: 1'b1},
        '{va: 11'd7,   wr: 1'b1, flt: 2'd0, pa: 10'd327, nc: 1'b0, nrd: 2'd2, nwr: 1'b1},
        '{va: 11'd7,   wr: 1'b1, flt: 2'd0, pa: 10'd327, nc: 1'b0, nrd: 2'd2, nwr: 1'b0},
        '{va: 11'd35,  wr: 1'b0, flt: 2'd0, pa: 10'd355, nc: 1'b0, nrd: 2'd2, nwr: 1'b0},
        '{va: 11'd35,  wr: 1'b1, flt: 2'd2, pa: 10'd0,   nc: 1'b0, nrd: 2'd2, nwr: 1'b0},
        '{va: 11'd256, wr: 1'b0, flt: 2'd1, pa: 10'd0,   nc: 1'b0, nrd: 2'd1, nwr: 1'b0},
        '{va: 11'd73,  wr: 1'b0, flt: 2'd1, pa: 10'd0,   nc: 1'b0, nrd: 2'd2, nwr: 1'b0},
        '{va: 11'd127, wr: 1'b0, flt: 2'd0, pa: 10'd415, nc: 1'b1, nrd: 2'd2, nwr: 1'b0},
        '{va: 11'd672, wr: 1'b1, flt: 2'd0, pa: 10'd992, nc: 1'b0, nrd: 2'd2, nwr: 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [BPA-1:0]  ptbr = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [BVA-1:0]  req_vaddr = '0;
    logic            req_write = 1'b0;
    logic            mem_req_valid;
    logic            mem_req_ready;
    logic            mem_req_write;
    logic [BPA-1:0]  mem_req_addr;
    logic [BPTE-1:0] mem_req_wdata;
    logic            mem_rsp_valid;
    logic [BPTE-1:0] mem_rsp_rdata;
    logic            done_valid;
    logic [BPA-1:0]  done_paddr;
    logic [1:0]      done_fault;
    logic            done_nocache;

    logic [BPTE-1:0] mem [WORDS];
    int              rd_cnt, wr_cnt;
    logic [BPA-1:0]  last_wr_addr;
    logic            stall_mode = 1'b0;
    logic            tog;
    int              checks = 0;
    int              errors = 0;
    bit              finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [BPTE-1:0] pte(input logic [4:0] ppn, input logic [4:0] fl);
        return {ppn, 22'd0, fl};
    endfunction

    assign mem_req_ready = stall_mode ? tog : 1'b1;

    // memory model, reloaded on reset
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            mem[0]  <= pte(5'd1, FP);
            mem[2]  <= pte(5'd2, FP);
            mem[8]  <= pte(5'd10, FP | FW);
            mem[9]  <= pte(5'd11, FP | FR);
            mem[11] <= pte(5'd12, FP | FW | FR | FM | FC);
            mem[16] <= pte(5'd7, FP);
            mem[21] <= pte(5'd31, FP | FW);
            mem[25] <= pte(5'd2, FP);
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
            rd_cnt <= 0;
            wr_cnt <= 0;
            last_wr_addr <= '0;
            tog <= 1'b0;
        end else begin
            tog <= ~tog;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                if (mem_req_write) begin
                    mem[mem_req_addr[BPA-1:2]] <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                    last_wr_addr <= mem_req_addr;
                end else begin
                    mem_rsp_rdata <= mem[mem_req_addr[BPA-1:2]];
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    pt_walker #(
        .LEVELS(BL), .IDX_W(BI), .OFF_W(BO), .PA_W(BPA), .PTE_W(BPTE)
    ) u0 (
        .clk(clk), .rst(rst), .ptbr(ptbr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .done_valid(done_valid), .done_paddr(done_paddr),
        .done_fault(done_fault), .done_nocache(done_nocache)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    logic [BPA-1:0] r_pa;
    logic [1:0]     r_flt;
    logic           r_nc;
    int             r_nrd, r_nwr;
    bit             r_busy_bad, r_timeout, r_pulse_bad;

    task automatic do_walk(input logic [BVA-1:0] va, input logic wr);
        int rd0, wr0, n;
        @(negedge clk);
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        r_busy_bad = 0;
        while (!done_valid && n < 300) begin
            if (req_ready) r_busy_bad = 1;
            @(negedge clk);
            n++;
        end
        r_timeout = !done_valid;
        r_pa  = done_paddr;
        r_flt = done_fault;
        r_nc  = done_nocache;
        r_nrd = rd_cnt - rd0;
        r_nwr = wr_cnt - wr0;
        @(negedge clk);
        r_pulse_bad = done_valid;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
        chk(done_valid == 1'b0, "R1 done_valid", done_valid, 0);

        for (int v = 0; v < NV; v++) begin
            do_walk(VECS[v].va, VECS[v].wr);
            chk(!r_timeout, "R12 walk completes", r_timeout, 0);
            chk(r_flt == VECS[v].flt, "R5 R6 fault code", r_flt, VECS[v].flt);
            chk(r_pa == VECS[v].pa, "R4 paddr", r_pa, VECS[v].pa);
            chk(r_nc == VECS[v].nc, "R10 nocache", r_nc, VECS[v].nc);
            chk(r_nrd == int'(VECS[v].nrd), "R4 R5 read count", r_nrd, VECS[v].nrd);
            chk(r_nwr == int'(VECS[v].nwr), "R9 write count", r_nwr, VECS[v].nwr);
            chk(!r_busy_bad, "R12 busy not ready", r_busy_bad, 0);
            chk(!r_pulse_bad, "R12 done pulse", r_pulse_bad, 0);
        end

        // R7 R8: entries after updates
        chk(mem[8] == pte(5'd10, FP | FW | FR | FM), "R8 entry word8", mem[8], pte(5'd10, FP | FW | FR | FM));
        chk(mem[9] == pte(5'd11, FP | FR), "R6 read-only entry unchanged", mem[9], pte(5'd11, FP | FR));
        chk(mem[21] == pte(5'd31, FP | FW | FR | FM), "R8 entry word21", mem[21], pte(5'd31, FP | FW | FR | FM));
        chk(last_wr_addr == 10'd84, "R3 write-back address", last_wr_addr, 84);
        chk(mem[11] == pte(5'd12, FP | FW | FR | FM | FC), "R9 uncached entry unchanged", mem[11], pte(5'd12, FP | FW | FR | FM | FC));

        // R7: read access sets only referenced
        do_reset();
        do_walk(11'd7, 1'b0);
        chk(mem[8] == pte(5'd10, FP | FW | FR), "R7 referenced only", mem[8], pte(5'd10, FP | FW | FR));

        // R2: base register not page aligned
        ptbr = 10'd100;
        do_walk(11'd7, 1'b0);
        chk(r_flt == 2'd0, "R2 fault", r_flt, 0);
        chk(r_pa == 10'd231, "R2 paddr via offset base", r_pa, 231);
        chk(r_nwr == 1, "R7 write count", r_nwr, 1);
        chk(mem[16] == pte(5'd7, FP | FR), "R7 entry word16", mem[16], pte(5'd7, FP | FR));
        ptbr = '0;

        // R11: stalling memory with a write-back
        do_reset();
        stall_mode = 1'b1;
        do_walk(11'd7, 1'b1);
        chk(!r_timeout, "R11 stalled walk completes", r_timeout, 0);
        chk(r_pa == 10'd327, "R11 stalled paddr", r_pa, 327);
        chk(r_nrd == 2 && r_nwr == 1, "R11 stalled access counts", r_nrd*10 + r_nwr, 21);
        chk(mem[8] == pte(5'd10, FP | FW | FR | FM), "R11 stalled write-back", mem[8], pte(5'd10, FP | FW | FR | FM));
        do_walk(11'd256, 1'b1);
        chk(r_flt == 2'd1 && r_nrd == 1 && r_nwr == 0, "R5 stalled top fault", r_flt, 1);
        stall_mode = 1'b0;

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule